// File: doc/BRIEF.md
# Mode-Banked Register File with Status Save

This block holds the general registers and the status word of a processor core that switches among several operating modes. Each mode sees fifteen general registers, numbered 0 to 14. Which physical storage sits behind a given register number depends on the current mode. Registers 0 to 7 are the same physical storage in every mode. The fast-interrupt mode has its own copies of registers 8 to 12. Every mode except User and System has its own stack and link registers, 13 and 14.

The block has two combinational read ports and one write port, which takes effect at the clock edge. It also holds the status word, which carries the condition flags, the two interrupt-disable bits, the instruction-set flag and the mode field. Each exception mode has a saved copy of the status word.

An exception-entry strobe, given with a target mode, switches the mode. It stores the old status word in the target mode's saved slot and sets the interrupt-disable bits. An exception-return strobe restores the status word from the current mode's saved slot. Software reaches the status word, and the saved copy of the current mode, through a write port, a select line and two read outputs.

Top module: `banked_regfile`

## Requirements
- R1: After reset the status word reads 0x000000D3 (Supervisor mode, both interrupt-disable bits set) and every general register reads 0.
- R2: Register numbers 0 to 7 name one physical register set in all modes. Reads are combinational, and a write is visible on the read ports after the next rising clock edge.
- R3: In fast-interrupt mode, register numbers 8 to 12 use storage private to that mode. All other modes share a single set for those numbers.
- R4: Register numbers 13 and 14 resolve to storage private to each of the fast-interrupt, interrupt, Supervisor, Abort and Undefined modes. User and System modes share one pair.
- R5: Register number 15 always reads 0, and a write to it changes nothing.
- R6: The status word holds flags N, Z, C and V at bits 31 to 28, interrupt disable at bit 7, fast-interrupt disable at bit 6, the instruction-set flag at bit 5 and the mode at bits 4 to 0. Mode codes: User 10000, fast-interrupt 10001, interrupt 10010, Supervisor 10011, Abort 10111, Undefined 11011, System 11111. An entry strobe with a target mode that has a saved slot does three things. It writes the prior status word into that slot. It sets the mode field to the target mode, and it sets bit 7. For the fast-interrupt target it also sets bit 6. All other bits keep their values.
- R7: An entry strobe whose target is User, System or an unlisted code changes nothing.
- R8: A return strobe in a mode that has a saved slot loads the status word from that slot. In User or System mode the strobe changes nothing.
- R9: A status-word write from User mode changes only bits 31 to 28. From any other mode it replaces the whole word.
- R10: In an exception mode, the saved-status output shows that mode's slot, and a saved-status write replaces that slot. In User or System mode the output reads 0 and a saved-status write changes nothing.
- R11: If strobes arrive in the same cycle, entry takes precedence over return, and return takes precedence over a status write. A general-register write in the same cycle uses the mode that held before the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_a_idx | input | 4 | Read port A register number |
| rd_a_data | output | 32 | Read port A data |
| rd_b_idx | input | 4 | Read port B register number |
| rd_b_data | output | 32 | Read port B data |
| wr_en | input | 1 | General-register write strobe |
| wr_idx | input | 4 | Write register number |
| wr_data | input | 32 | Write data |
| psr_wr_en | input | 1 | Status write strobe |
| psr_wr_saved | input | 1 | 1 targets the saved slot, 0 the status word |
| psr_wr_data | input | 32 | Status write data |
| exc_enter | input | 1 | Exception entry strobe |
| exc_mode | input | 5 | Target mode for entry |
| exc_return | input | 1 | Exception return strobe |
| psr_cur | output | 32 | Current status word |
| psr_saved | output | 32 | Saved status of current mode |

## Verification
Read data follows the register number and the current mode combinationally, so the bench checks it in the same cycle it sets the number. Every write, entry and return is due exactly one rising edge after its strobe. The bench drives each strobe shortly after one edge and samples the outputs a little after the following edge, never at the edge itself. This placement includes the combined-strobe case, in which the register write has to land in the bank of the old mode.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int          W       = 32,
  parameter logic [31:0] RST_PSR = 32'h0000_00D3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   rd_a_idx,
  output logic [W-1:0] rd_a_data,
  input  logic [3:0]   rd_b_idx,
  output logic [W-1:0] rd_b_data,
  input  logic         wr_en,
  input  logic [3:0]   wr_idx,
  input  logic [W-1:0] wr_data,
  input  logic         psr_wr_en,
  input  logic         psr_wr_saved,
  input  logic [W-1:0] psr_wr_data,
  input  logic         exc_enter,
  input  logic [4:0]   exc_mode,
  input  logic         exc_return,
  output logic [W-1:0] psr_cur,
  output logic [W-1:0] psr_saved
);
  localparam logic [4:0] M_USR = 5'b10000, M_FIQ = 5'b10001, M_IRQ = 5'b10010,
                         M_SVC = 5'b10011, M_ABT = 5'b10111, M_UND = 5'b11011;
  localparam int NBANK = 6;

  logic [W-1:0] lo_q   [8];
  logic [W-1:0] hi_q   [5];
  logic [W-1:0] fhi_q  [5];
  logic [W-1:0] sp_q   [NBANK];
  logic [W-1:0] lr_q   [NBANK];
  logic [W-1:0] spsr_q [NBANK];
  logic [W-1:0] psr_q;

  function automatic logic [2:0] bank_of(input logic [4:0] m);
    case (m)
      M_FIQ:   return 3'd1;
      M_IRQ:   return 3'd2;
      M_SVC:   return 3'd3;
      M_ABT:   return 3'd4;
      M_UND:   return 3'd5;
      default: return 3'd0;
    endcase
  endfunction

  logic [2:0] cur_bank, tgt_bank;
  logic       in_fiq, in_usr;
  logic [W-1:0] entry_psr;

  assign cur_bank  = bank_of(psr_q[4:0]);
  assign tgt_bank  = bank_of(exc_mode);
  assign in_fiq    = (cur_bank == 3'd1);
  assign in_usr    = (psr_q[4:0] == M_USR);
  assign entry_psr = {psr_q[W-1:8], 1'b1, psr_q[6] | (exc_mode == M_FIQ), psr_q[5], exc_mode};

  function automatic logic [W-1:0] rd(input logic [3:0] i);
    if (i < 4'd8)       return lo_q[i[2:0]];
    else if (i < 4'd13) return in_fiq ? fhi_q[i[2:0]] : hi_q[i[2:0]];
    else if (i == 4'd13) return sp_q[cur_bank];
    else if (i == 4'd14) return lr_q[cur_bank];
    else                return '0;
  endfunction

  assign rd_a_data = rd(rd_a_idx);
  assign rd_b_data = rd(rd_b_idx);
  assign psr_cur   = psr_q;
  assign psr_saved = (cur_bank != 3'd0) ? spsr_q[cur_bank] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 8; i++) lo_q[i] <= '0;
      for (int i = 0; i < 5; i++) begin
        hi_q[i]  <= '0;
        fhi_q[i] <= '0;
      end
      for (int i = 0; i < NBANK; i++) begin
        sp_q[i]   <= '0;
        lr_q[i]   <= '0;
        spsr_q[i] <= '0;
      end
      psr_q <= RST_PSR[W-1:0];
    end else begin
      if (wr_en) begin
        if (wr_idx < 4'd8)        lo_q[wr_idx[2:0]] <= wr_data;
        else if (wr_idx < 4'd13) begin
          if (in_fiq) fhi_q[wr_idx[2:0]] <= wr_data;
          else        hi_q[wr_idx[2:0]]  <= wr_data;
        end
        else if (wr_idx == 4'd13) sp_q[cur_bank] <= wr_data;
        else if (wr_idx == 4'd14) lr_q[cur_bank] <= wr_data;
      end
      if (exc_enter) begin
        if (tgt_bank != 3'd0) begin
          spsr_q[tgt_bank] <= psr_q;
          psr_q            <= entry_psr;
        end
      end else if (exc_return) begin
        if (cur_bank != 3'd0) psr_q <= spsr_q[cur_bank];
      end else if (psr_wr_en) begin
        if (psr_wr_saved) begin
          if (cur_bank != 3'd0) spsr_q[cur_bank] <= psr_wr_data;
        end else if (in_usr) begin
          psr_q <= {psr_wr_data[W-1:W-4], psr_q[W-5:0]};
        end else begin
          psr_q <= psr_wr_data;
        end
      end
    end
  end
endmodule

// File: rtl/banked_regfile_checker.sv
module banked_regfile_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [3:0]  rd_a_idx,
  input logic [31:0] rd_a_data,
  input logic        psr_wr_en,
  input logic        psr_wr_saved,
  input logic        exc_enter,
  input logic [4:0]  exc_mode,
  input logic        exc_return,
  input logic [31:0] psr_cur,
  input logic [31:0] psr_saved
);
  logic tgt_ok, cur_plain;
  assign tgt_ok    = exc_mode inside {5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011};
  assign cur_plain = (psr_cur[4:0] == 5'b10000) || (psr_cur[4:0] == 5'b11111);

  assert_entry_save_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && tgt_ok) |=>
      (psr_cur[4:0] == $past(exc_mode)) && (psr_saved == $past(psr_cur)) && psr_cur[7]);

  assert_bad_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_enter && !tgt_ok && !exc_return && !psr_wr_en) |=> $stable(psr_cur));

  assert_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_return && !exc_enter && !cur_plain) |=> (psr_cur == $past(psr_saved)));

  assert_user_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (psr_wr_en && !psr_wr_saved && !exc_enter && !exc_return && psr_cur[4:0] == 5'b10000)
      |=> (psr_cur[27:0] == $past(psr_cur[27:0])));

  assert_saved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cur_plain |-> (psr_saved == 32'h0));

  assert_idx15_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_idx == 4'd15) |-> (rd_a_data == 32'h0));
endmodule

bind banked_regfile banked_regfile_checker u_chk (.*);

// File: tb/banked_regfile_bench.sv
`timescale 1ns/1ps
module banked_regfile_bench;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  rd_a_idx = 0, rd_b_idx = 0, wr_idx = 0;
  logic [31:0] rd_a_data, rd_b_data, wr_data = 0, psr_wr_data = 0, psr_cur, psr_saved;
  logic        wr_en = 0, psr_wr_en = 0, psr_wr_saved = 0, exc_enter = 0, exc_return = 0;
  logic [4:0]  exc_mode = 0;
  int n_run = 0, n_fail = 0;

  always #4 clk = ~clk;

  banked_regfile u_banked_regfile (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
    wr_en = 0; psr_wr_en = 0; psr_wr_saved = 0; exc_enter = 0; exc_return = 0;
  endtask

  task automatic wreg(logic [3:0] i, logic [31:0] d);
    wr_en = 1; wr_idx = i; wr_data = d; tick();
  endtask

  function automatic logic [31:0] rreg(logic [3:0] i);
    return 32'h0;
  endfunction

  task automatic read_chk(string req, logic [3:0] i, logic [31:0] exp);
    rd_a_idx = i; rd_b_idx = i; #1;
    chk(req, rd_a_data, exp);
    chk(req, rd_b_data, exp);
  endtask

  task automatic wpsr(logic saved, logic [31:0] d);
    psr_wr_en = 1; psr_wr_saved = saved; psr_wr_data = d; tick();
  endtask

  task automatic enter(logic [4:0] m);
    exc_enter = 1; exc_mode = m; tick();
  endtask

  task automatic ret();
    exc_return = 1; tick();
  endtask

  task automatic t_reset();
    chk("R1 psr", psr_cur, 32'h0000_00D3);
    read_chk("R1 r0", 0, 0);
    read_chk("R1 r8", 8, 0);
    read_chk("R1 r14", 14, 0);
  endtask

  task automatic t_user_setup();
    wreg(3, 32'h33); wreg(9, 32'hA9); wreg(13, 32'h5D);
    read_chk("R2 r3 write", 3, 32'h33);
    wpsr(0, 32'h10);
    chk("R9 priv write", psr_cur, 32'h10);
    read_chk("R2 r3 shared", 3, 32'h33);
    read_chk("R3 r9 shared", 9, 32'hA9);
    read_chk("R4 user r13", 13, 0);
    wreg(13, 32'h1313); wreg(14, 32'h1414);
    wpsr(0, 32'hF000_00DF);
    chk("R9 user write", psr_cur, 32'hF000_0010);
    chk("R10 user saved", psr_saved, 0);
    wpsr(1, 32'hDEAD_BEEF);
    chk("R10 user saved write", psr_cur, 32'hF000_0010);
    chk("R10 user saved after", psr_saved, 0);
  endtask

  task automatic t_fiq();
    enter(5'b10001);
    chk("R6 fiq psr", psr_cur, 32'hF000_00D1);
    chk("R6 fiq saved", psr_saved, 32'hF000_0010);
    read_chk("R3 fiq r9", 9, 0);
    read_chk("R4 fiq r13", 13, 0);
    read_chk("R2 fiq r3", 3, 32'h33);
    wreg(9, 32'hF9); wreg(13, 32'hF13);
    ret();
    chk("R8 fiq return", psr_cur, 32'hF000_0010);
    read_chk("R3 back r9", 9, 32'hA9);
    read_chk("R4 back r13", 13, 32'h1313);
  endtask

  task automatic t_irq_svc();
    enter(5'b10010);
    chk("R6 irq psr", psr_cur, 32'hF000_0092);
    read_chk("R3 irq r9", 9, 32'hA9);
    read_chk("R4 irq r13", 13, 0);
    wpsr(1, 32'h2000_0010);
    chk("R10 saved write", psr_saved, 32'h2000_0010);
    ret();
    chk("R8 restore", psr_cur, 32'h2000_0010);
    enter(5'b10011);
    chk("R6 svc psr", psr_cur, 32'h2000_0093);
    chk("R6 svc saved", psr_saved, 32'h2000_0010);
    read_chk("R4 svc r13", 13, 32'h5D);
    enter(5'b10001);
    read_chk("R3 fiq kept r9", 9, 32'hF9);
    ret();
  endtask

  task automatic t_system();
    wpsr(0, 32'h1F);
    chk("R9 sys write", psr_cur, 32'h1F);
    read_chk("R4 sys r13", 13, 32'h1313);
    read_chk("R4 sys r14", 14, 32'h1414);
    chk("R10 sys saved", psr_saved, 0);
    ret();
    chk("R8 sys return", psr_cur, 32'h1F);
    enter(5'b10000);
    chk("R7 usr entry", psr_cur, 32'h1F);
    enter(5'b10101);
    chk("R7 bad entry", psr_cur, 32'h1F);
    wreg(15, 32'h5555);
    read_chk("R5 r15", 15, 0);
    read_chk("R5 r3 intact", 3, 32'h33);
  endtask

  task automatic t_priority();
    exc_enter = 1; exc_mode = 5'b10010; exc_return = 1;
    psr_wr_en = 1; psr_wr_data = 32'h0;
    wr_en = 1; wr_idx = 13; wr_data = 32'hBEEF;
    tick();
    chk("R11 entry wins", psr_cur, 32'h0000_0092);
    chk("R11 saved", psr_saved, 32'h1F);
    read_chk("R11 irq r13", 13, 0);
    ret();
    read_chk("R11 old bank r13", 13, 32'hBEEF);
  endtask

  initial begin
    #20 rst_n = 1;
    #1;
    t_reset();
    #10;
    @(negedge clk);
    t_user_setup();
    t_fiq();
    t_irq_svc();
    t_system();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #200000;
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule